// File: doc/BRIEF.md
# Stepper Phase Excitation Sequencer

This block turns a slow step clock into the four unipolar coil drive lines of a two-phase stepping motor. It keeps a three-bit position inside an eight-entry electrical cycle and turns that position into an on/off pattern for the coils. The coil lines are called A, AB, B and BB, where AB and BB are the opposite-polarity windings of A and B. Every qualified step-clock transition moves the position by one slot or by two. The move depends on the selected excitation style and the rotation sense. The block runs on a fast system clock. It samples the asynchronous step clock through a short synchroniser before it looks for edges.

Two excitation styles are available. Full-step keeps two coils energised at every position. Half-step alternates between two-coil and one-coil positions. An edge-select input chooses whether the step clock counts on rising transitions only or on both transitions. An enable input forces every coil line off but leaves the position untouched, so stepping resumes exactly where it stopped. A reset places the rotor at the position with A and BB energised. When no transitions arrive, the last pattern stays applied, and this holding torque keeps the rotor in place.

Top module: `step_seq_top`

## Requirements
- R1: With `half_step_i` low, each qualified step edge moves between two-coil positions only. Forward order: A+BB, A+B, B+AB, AB+BB, then back to A+BB.
- R2: With `half_step_i` high, each qualified edge moves one slot through eight positions, numbered 0 to 7 forward: 0=A+BB, 1=A, 2=A+B, 3=B, 4=B+AB, 5=AB, 6=AB+BB, 7=BB.
- R3: With `rise_only_i` high, only low-to-high transitions of `step_clk_i` step the position. With it low, both transitions step. The coil outputs reflect a step no later than three system clock cycles after the step-clock transition.
- R4: With `dir_rev_i` low the position moves forward (increasing slot number, wrapping 7 to 0). With it high the position moves in reverse.
- R5: While `rst_n` is low the position is slot 0, so A and BB are on and AB and B are off. This applies whether reset comes at power-up or in the middle of a run.
- R6: With `enable_i` low all four coil outputs are 0. Steps taken meanwhile still move the position, and raising enable again shows the pattern of the current position.
- R7: Changing `half_step_i` does not move the position. A full-step edge taken from a one-coil slot moves to the neighbouring two-coil slot in the current direction (one slot, not two).
- R8: Without a qualified step edge, the position and the coil outputs stay constant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Asynchronous active-low reset to slot 0 |
| step_clk_i | input | 1 | Asynchronous step clock, low during reset |
| half_step_i | input | 1 | 1 = half-step, 0 = full-step |
| rise_only_i | input | 1 | 1 = rising edges only, 0 = both edges |
| dir_rev_i | input | 1 | 0 = forward, 1 = reverse |
| enable_i | input | 1 | 0 = all coil outputs off |
| coil_a_o | output | 1 | Coil A drive |
| coil_ab_o | output | 1 | Coil AB drive (opposite of A) |
| coil_b_o | output | 1 | Coil B drive |
| coil_bb_o | output | 1 | Coil BB drive (opposite of B) |

## Verification
The hardest case to reach is a full-step edge taken from a one-coil slot. The position has to land on an odd slot in half-step first, and then the mode must change between two step-clock transitions. The directed part of the stimulus does this in both directions. The random part changes mode, direction, edge selection and enable between transitions, so odd slots are met again and again in full-step. Steps taken with enable low are only visible after enable returns. The bench therefore compares the pattern shown once enable comes back against its own position model.

// File: rtl/step_seq_pkg.sv
package step_seq_pkg;
    // Eight electrical slots per cycle; even slots have two coils on.
    localparam int POS_W     = 3;
    localparam int NUM_COILS = 4;

    typedef logic [POS_W-1:0] pos_t;

    // Coil order inside the internal vector: A, B, AB, BB (quarter-cycle apart).
    typedef logic [NUM_COILS-1:0] coil_vec_t;

    typedef struct packed {
        pos_t pos;
    } pos_reg_t;
endpackage

// File: rtl/step_edge_detect.sv
module step_edge_detect #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step_clk_i,
    input  logic rise_only_i,
    output logic step_edge_o
);
    localparam int CHAIN_W = SYNC_STAGES + 1;   // synchroniser plus history flop

    typedef struct packed {
        logic [CHAIN_W-1:0] chain;
    } sync_reg_t;

    sync_reg_t sync_d, sync_q;
    logic      cur_lvl;
    logic      prev_lvl;

    always_comb begin
        sync_d       = sync_q;
        sync_d.chain = {sync_q.chain[CHAIN_W-2:0], step_clk_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign cur_lvl  = sync_q.chain[SYNC_STAGES-1];
    assign prev_lvl = sync_q.chain[SYNC_STAGES];

    always_comb begin
        if (rise_only_i) begin
            step_edge_o = cur_lvl & ~prev_lvl;
        end else begin
            step_edge_o = cur_lvl ^ prev_lvl;
        end
    end
endmodule

// File: rtl/step_position.sv
module step_position
    import step_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic step_edge_i,
    input  logic half_step_i,
    input  logic dir_rev_i,
    output pos_t pos_o
);
    pos_reg_t pos_d, pos_q;
    pos_t     stride;

    always_comb begin
        pos_d = pos_q;
        // Half-step: one slot. Full-step: two slots from an even slot,
        // one slot from an odd slot to realign to a two-coil position.
        if (half_step_i || pos_q.pos[0]) begin
            stride = pos_t'(1);
        end else begin
            stride = pos_t'(2);
        end
        if (step_edge_i) begin
            if (dir_rev_i) begin
                pos_d.pos = pos_q.pos - stride;
            end else begin
                pos_d.pos = pos_q.pos + stride;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q <= '0;
        end else begin
            pos_q <= pos_d;
        end
    end

    assign pos_o = pos_q.pos;
endmodule

// File: rtl/step_phase_decode.sv
module step_phase_decode
    import step_seq_pkg::*;
(
    input  pos_t      pos_i,
    input  logic      enable_i,
    output coil_vec_t coil_o
);
    // Coil k is on for the three slots starting at slot 2k.
    for (genvar k = 0; k < NUM_COILS; k++) begin : g_coil
        pos_t rel;
        assign rel       = pos_i - pos_t'(2 * k);
        assign coil_o[k] = enable_i & (rel <= pos_t'(2));
    end
endmodule

// File: rtl/step_seq_top.sv
module step_seq_top
    import step_seq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step_clk_i,
    input  logic half_step_i,
    input  logic rise_only_i,
    input  logic dir_rev_i,
    input  logic enable_i,
    output logic coil_a_o,
    output logic coil_ab_o,
    output logic coil_b_o,
    output logic coil_bb_o
);
    logic      step_edge;
    pos_t      pos_q;
    coil_vec_t coils;

    step_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) edge_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .step_clk_i  (step_clk_i),
        .rise_only_i (rise_only_i),
        .step_edge_o (step_edge)
    );

    step_position pos_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .step_edge_i (step_edge),
        .half_step_i (half_step_i),
        .dir_rev_i   (dir_rev_i),
        .pos_o       (pos_q)
    );

    step_phase_decode dec_i (
        .pos_i    (pos_q),
        .enable_i (enable_i),
        .coil_o   (coils)
    );

    assign coil_a_o  = coils[0];
    assign coil_b_o  = coils[1];
    assign coil_ab_o = coils[2];
    assign coil_bb_o = coils[3];
endmodule

// File: rtl/step_seq_checker.sv
module step_seq_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       step_edge,
    input logic       half_step_i,
    input logic       dir_rev_i,
    input logic       enable_i,
    input logic [2:0] pos,
    input logic [3:0] coil_bus
);
    p_reset_slot_r5: assert property (@(posedge clk)
        !rst_n |-> (pos == 3'd0));

    p_enable_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |-> (coil_bus == 4'b0000));

    p_coil_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
        enable_i |-> ($countones(coil_bus) == 1 || $countones(coil_bus) == 2));

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !step_edge |=> $stable(pos));

    p_half_fwd_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (step_edge && half_step_i && !dir_rev_i) |=> (pos == 3'($past(pos) + 3'd1)));

    p_half_rev_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (step_edge && half_step_i && dir_rev_i) |=> (pos == 3'($past(pos) - 3'd1)));

    p_full_even_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (step_edge && !half_step_i) |=> (pos[0] == 1'b0));

    p_full_realign_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (step_edge && !half_step_i && pos[0]) |=>
            (pos == 3'($past(pos) + 3'd1) || pos == 3'($past(pos) - 3'd1)));
endmodule

bind step_seq_top step_seq_checker chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .step_edge   (step_edge),
    .half_step_i (half_step_i),
    .dir_rev_i   (dir_rev_i),
    .enable_i    (enable_i),
    .pos         (pos_q),
    .coil_bus    ({coil_a_o, coil_ab_o, coil_b_o, coil_bb_o})
);

// File: tb/step_seq_top_tb_top.sv
module step_seq_top_tb_top;
    logic clk = 1'b0;
    logic rst_n;
    logic step_clk, half_step, rise_only, dir_rev, enable;
    logic coil_a, coil_ab, coil_b, coil_bb;

    int   n_checks = 0;
    int   n_bad    = 0;
    bit   finished = 1'b0;
    logic [2:0] model_pos;

    always #10 clk = ~clk;   // 50 MHz

    step_seq_top dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .step_clk_i  (step_clk),
        .half_step_i (half_step),
        .rise_only_i (rise_only),
        .dir_rev_i   (dir_rev),
        .enable_i    (enable),
        .coil_a_o    (coil_a),
        .coil_ab_o   (coil_ab),
        .coil_b_o    (coil_b),
        .coil_bb_o   (coil_bb)
    );

    // Expected {A, AB, B, BB} for each slot, from the slot list of R2.
    function automatic logic [3:0] slot_pattern(input logic [2:0] p);
        case (p)
            3'd0:    return 4'b1001;
            3'd1:    return 4'b1000;
            3'd2:    return 4'b1010;
            3'd3:    return 4'b0010;
            3'd4:    return 4'b0110;
            3'd5:    return 4'b0100;
            3'd6:    return 4'b0101;
            default: return 4'b0001;
        endcase
    endfunction

    function automatic logic [2:0] model_step(input logic [2:0] p, input logic hs, input logic rev);
        int amount;
        amount = (hs || p[0]) ? 1 : 2;
        return rev ? 3'(p - 3'(amount)) : 3'(p + 3'(amount));
    endfunction

    task automatic check(input string tag);
        logic [3:0] got, exp;
        got = {coil_a, coil_ab, coil_b, coil_bb};
        exp = enable ? slot_pattern(model_pos) : 4'b0000;
        n_checks++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: coils=%b expected=%b (slot %0d)", tag, got, exp, model_pos);
        end
    endtask

    task automatic settle();
        repeat (4) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic toggle_step();
        @(negedge clk);
        step_clk = ~step_clk;
        if (step_clk || !rise_only) model_pos = model_step(model_pos, half_step, dir_rev);
        settle();
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n     = 1'b0;
        step_clk  = 1'b0;
        model_pos = 3'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_bad++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        rst_n = 1'b0; step_clk = 1'b0; half_step = 1'b1; rise_only = 1'b0;
        dir_rev = 1'b0; enable = 1'b1; model_pos = 3'd0;
        repeat (3) @(negedge clk);
        check("R5 reset slot");
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R5 after release");

        // R2 half-step forward through a full cycle, both edges (R3)
        for (int i = 0; i < 8; i++) begin
            toggle_step();
            check("R2 half-step forward");
        end
        // R4 reverse
        dir_rev = 1'b1;
        for (int i = 0; i < 3; i++) begin
            toggle_step();
            check("R4 half-step reverse");
        end
        // R8 hold: nothing moves without edges
        repeat (25) @(negedge clk);
        check("R8 hold with fixed step clock");

        // R3 rise-only: falling transitions ignored
        if (step_clk) toggle_step();
        rise_only = 1'b1; dir_rev = 1'b0;
        toggle_step(); check("R3 rising edge steps");
        toggle_step(); check("R3 falling edge ignored");
        toggle_step(); check("R3 rising edge steps again");
        toggle_step();
        rise_only = 1'b0;

        // R1 full-step from an even slot
        do_reset();
        half_step = 1'b0;
        for (int i = 0; i < 5; i++) begin
            toggle_step();
            check("R1 full-step forward");
        end

        // R7 mode change on an odd slot, forward and reverse
        half_step = 1'b1;
        toggle_step(); check("R7 half-step to one-coil slot");
        half_step = 1'b0;
        settle(); check("R7 mode change keeps slot");
        toggle_step(); check("R7 full-step realign forward");
        half_step = 1'b1; toggle_step();
        half_step = 1'b0; dir_rev = 1'b1;
        toggle_step(); check("R7 full-step realign reverse");
        dir_rev = 1'b0;

        // R6 enable off while stepping
        enable = 1'b0;
        settle(); check("R6 outputs off");
        toggle_step(); toggle_step(); check("R6 outputs stay off while stepping");
        enable = 1'b1;
        settle(); check("R6 resume at advanced slot");

        // R5 reset in the middle of a run
        half_step = 1'b1; toggle_step();
        do_reset();
        check("R5 mid-run reset");

        // Random mix
        for (int i = 0; i < 300; i++) begin
            half_step = 1'($urandom_range(0, 1));
            dir_rev   = 1'($urandom_range(0, 1));
            rise_only = 1'($urandom_range(0, 1));
            enable    = ($urandom_range(0, 3) != 0);
            toggle_step();
            if (!enable)        check("R6 random");
            else if (half_step) check("R2 random");
            else                check("R1 random");
        end

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end
endmodule